// File: doc/BRIEF.md
# Pipelined Dual-Bank Dot-Product Engine

This block computes the signed dot product of two vectors, each stored in its own synchronous memory bank. A start pulse captures a base address for each vector and an element count. From then on, the block does three things at once, each in its own pipeline stage:

- it advances both operand pointers;
- it reads one element from each bank in the same clock;
- it multiplies the previous pair and adds the product into a wide accumulator.

In steady state, one product is accumulated per clock with no loop overhead. The pointers are stepped by dedicated address registers, not by the accumulator's adder.

Each bank is loaded through its own write port. After a run finishes, the block raises a one-cycle `done` pulse. The accumulator output then keeps the final sum until the next accepted start.

The controller is a three-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Waiting for a start |
| `ST_ISSUE` | Stepping the pointers, one element per clock |
| `ST_DRAIN` | Letting the last two elements flow through the read and accumulate stages |

Transitions:

- `ST_IDLE` to `ST_ISSUE` on a start with a non-zero count.
- `ST_IDLE` back to `ST_IDLE` on a start with a zero count. This raises `done` at once.
- `ST_ISSUE` to `ST_DRAIN` when the final element is issued.
- `ST_DRAIN` to `ST_IDLE` on the clock that accumulates the final product.

Top module: `dual_bank_mac`

## Requirements
- R1: After reset, `done` is 0, `busy` is 0 and `acc_out` is 0.
- R2: A start with count N>0 in idle produces `acc_out` = sum for j=0..N-1 of A[(base_x+j) mod 256] * B[(base_y+j) mod 256]. Operands are 16-bit signed two's complement values, and the sum is presented when `done` is high.
- R3: Call the clock edge that samples the start edge 0. The first product appears in `acc_out` after edge 3. `done` is low in the cycle after edge N+1 and high in the cycle after edge N+2.
- R4: `done` is high for exactly one cycle. While idle with no start, `acc_out` holds its value.
- R5: An accepted start clears `acc_out` to 0 at edge 0. It stays 0 through the cycle after edge 2.
- R6: A start with count 0 raises `done` in the cycle after edge 0, with `acc_out` = 0 and `busy` staying 0.
- R7: `busy` is high from the cycle after edge 0 through the cycle after edge N+1. It is low when `done` is high.
- R8: A start asserted while `busy` is high is ignored. The running sum, its timing and its result are unchanged.
- R9: Both pointers increment by 1 and wrap modulo the 256-word bank depth.
- R10: The accumulator is 40 bits wide. 256 products of (-32768)*(-32768) sum exactly to 2^38.
- R11: A write on a bank's write port stores the data at the given address on that clock edge. It is seen by any run started afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| base_x | input | 8 | First address of the vector in bank A |
| base_y | input | 8 | First address of the vector in bank B |
| count | input | 9 | Number of elements (0 to 256) |
| a_wr_en | input | 1 | Bank A write enable |
| a_wr_addr | input | 8 | Bank A write address |
| a_wr_data | input | 16 | Bank A write data |
| b_wr_en | input | 1 | Bank B write enable |
| b_wr_addr | input | 8 | Bank B write address |
| b_wr_data | input | 16 | Bank B write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 40 | Signed accumulator |

## Verification
The bench goes after each timing and arithmetic corner case, and names the failure each would expose:

- Exact fill and drain latency: an engine with one stage too many or too few would pulse `done` a cycle early or late, or would drop or double-count the first or last product.
- Runs whose address windows cross the top of a bank: a pointer that fails to wrap would read the wrong words.
- A full 256-element run of the most negative operands: a narrow or zero-extended accumulator would give the wrong sign or overflow.
- A zero-length run: this must pulse `done` without entering the pipeline.
- A second start issued mid-run: a design that accepts it would restart and return a different sum at a different time.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } mac_state_t;

    localparam int LANES = 2;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic             final_acc,
    output logic             busy,
    output logic             load,
    output logic             issue,
    output logic             issue_last,
    output logic             zero_done
);
    mac_state_t       state, state_nx;
    logic [CNT_W-1:0] remain;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Elements still to issue
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     remain <= '0;
        else if (load)  remain <= count;
        else if (issue) remain <= remain - CNT_W'(1);
    end

    // Next state and outputs
    always_comb begin
        state_nx   = state;
        busy       = 1'b0;
        load       = 1'b0;
        issue      = 1'b0;
        issue_last = 1'b0;
        zero_done  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (count == '0) begin
                        zero_done = 1'b1;
                    end else begin
                        load     = 1'b1;
                        state_nx = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                busy  = 1'b1;
                issue = 1'b1;
                if (remain == CNT_W'(1)) begin
                    issue_last = 1'b1;
                    state_nx   = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                busy = 1'b1;
                if (final_acc) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/mac_agu.sv
module mac_agu #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] next_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_ptr <= '0;
            addr     <= '0;
        end else if (load) begin
            next_ptr <= base;
        end else if (step) begin
            addr     <= next_ptr;
            next_ptr <= next_ptr + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/mac_bank.sv
module mac_bank #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/mac_acc.sv
module mac_acc #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output logic [ACC_W-1:0]  acc
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod;
    logic        [ACC_W-1:0]  prod_ext;

    always_comb begin
        prod     = $signed(x) * $signed(y);
        prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc <= '0;
        else if (clear) acc <= '0;
        else if (en)    acc <= acc + prod_ext;
    end
endmodule

// File: rtl/dual_bank_mac.sv
module dual_bank_mac
    import mac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int ACC_W  = 40,
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_x,
    input  logic [ADDR_W-1:0] base_y,
    input  logic [CNT_W-1:0]  count,
    input  logic              a_wr_en,
    input  logic [ADDR_W-1:0] a_wr_addr,
    input  logic [DATA_W-1:0] a_wr_data,
    input  logic              b_wr_en,
    input  logic [ADDR_W-1:0] b_wr_addr,
    input  logic [DATA_W-1:0] b_wr_data,
    output logic              busy,
    output logic              done,
    output logic [ACC_W-1:0]  acc_out
);
    logic load, issue, issue_last, zero_done, final_acc;
    logic s1_valid, s1_last, s2_valid, s2_last;

    logic [ADDR_W-1:0] lane_base  [LANES];
    logic [ADDR_W-1:0] lane_addr  [LANES];
    logic              lane_we    [LANES];
    logic [ADDR_W-1:0] lane_waddr [LANES];
    logic [DATA_W-1:0] lane_wdata [LANES];
    logic [DATA_W-1:0] lane_rdata [LANES];

    always_comb begin
        lane_base[0]  = base_x;
        lane_base[1]  = base_y;
        lane_we[0]    = a_wr_en;
        lane_we[1]    = b_wr_en;
        lane_waddr[0] = a_wr_addr;
        lane_waddr[1] = b_wr_addr;
        lane_wdata[0] = a_wr_data;
        lane_wdata[1] = b_wr_data;
    end

    mac_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .count      (count),
        .final_acc  (final_acc),
        .busy       (busy),
        .load       (load),
        .issue      (issue),
        .issue_last (issue_last),
        .zero_done  (zero_done)
    );

    // One pointer unit and one bank per operand lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        mac_agu #(.ADDR_W(ADDR_W)) u_agu (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .base  (lane_base[g]),
            .step  (issue),
            .addr  (lane_addr[g])
        );
        mac_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
            .clk   (clk),
            .we    (lane_we[g]),
            .waddr (lane_waddr[g]),
            .wdata (lane_wdata[g]),
            .raddr (lane_addr[g]),
            .rdata (lane_rdata[g])
        );
    end

    // Stage valid flags: pointer stage, read stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_last  <= 1'b0;
            s2_valid <= 1'b0;
            s2_last  <= 1'b0;
        end else begin
            s1_valid <= issue;
            s1_last  <= issue_last;
            s2_valid <= s1_valid;
            s2_last  <= s1_last;
        end
    end

    assign final_acc = s2_valid & s2_last;

    mac_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load | zero_done),
        .en    (s2_valid),
        .x     (lane_rdata[0]),
        .y     (lane_rdata[1]),
        .acc   (acc_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= zero_done | final_acc;
    end
endmodule

// File: rtl/dual_bank_mac_chk.sv
module dual_bank_mac_chk #(
    parameter int ACC_W = 40,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] count,
    input logic             busy,
    input logic             done,
    input logic [ACC_W-1:0] acc_out
);
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R5
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (acc_out == '0));

    // R6
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && count == '0) |=> (done && !busy));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(acc_out));
endmodule

bind dual_bank_mac dual_bank_mac_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .count   (count),
    .busy    (busy),
    .done    (done),
    .acc_out (acc_out)
);

// File: tb/tb_dual_bank_mac.sv
module tb_dual_bank_mac;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;

    typedef struct packed {
        logic [7:0] bx;
        logic [7:0] by;
        logic [8:0] n;
    } vec_t;

    // base_x, base_y, count
    localparam vec_t VECS [NVEC] = '{
        '{8'd0,   8'd0,   9'd5},
        '{8'd17,  8'd100, 9'd1},
        '{8'd250, 8'd5,   9'd12},
        '{8'd3,   8'd240, 9'd40},
        '{8'd0,   8'd128, 9'd256}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  base_x = '0, base_y = '0;
    logic [8:0]  count = '0;
    logic        a_wr_en = 1'b0, b_wr_en = 1'b0;
    logic [7:0]  a_wr_addr = '0, b_wr_addr = '0;
    logic [15:0] a_wr_data = '0, b_wr_data = '0;
    logic        busy, done;
    logic [39:0] acc_out;

    logic signed [15:0] ma [256];
    logic signed [15:0] mb [256];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_bank_mac dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base_x(base_x), .base_y(base_y), .count(count),
        .a_wr_en(a_wr_en), .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
        .b_wr_en(b_wr_en), .b_wr_addr(b_wr_addr), .b_wr_data(b_wr_data),
        .busy(busy), .done(done), .acc_out(acc_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_both(input int addr, input logic [15:0] da, input logic [15:0] db);
        @(negedge clk);
        a_wr_en = 1'b1; a_wr_addr = 8'(addr); a_wr_data = da;
        b_wr_en = 1'b1; b_wr_addr = 8'(addr); b_wr_data = db;
        ma[addr] = da;
        mb[addr] = db;
        @(negedge clk);
        a_wr_en = 1'b0; b_wr_en = 1'b0;
    endtask

    function automatic logic signed [39:0] prod(input int ia, input int ib);
        logic signed [31:0] p;
        p = ma[ia & 255] * mb[ib & 255];
        return 40'(p);
    endfunction

    function automatic logic signed [39:0] dot(input int bx, input int by, input int n);
        logic signed [39:0] s;
        s = '0;
        for (int j = 0; j < n; j++) s = s + prod(bx + j, by + j);
        return s;
    endfunction

    // Start a run, optionally poking a second start at index poke
    task automatic run(input int bx, input int by, input int n, input int poke, input string tag);
        logic signed [39:0] exp;
        exp = dot(bx, by, n);
        @(negedge clk);
        start = 1'b1; base_x = 8'(bx); base_y = 8'(by); count = 9'(n);
        for (int k = 0; k <= n + 3; k++) begin
            @(negedge clk);
            if (k == 0 || k == poke + 1) start = 1'b0;
            if (k == poke) begin
                start = 1'b1; base_x = 8'(bx + 7); base_y = 8'(by + 3); count = 9'd3;
            end
            if (k == 2)
                chk(acc_out == '0, {tag, " R5 acc zero before first MAC"}, $signed(acc_out), 0);
            if (k == 3 && n > 1)
                chk($signed(acc_out) == prod(bx, by), {tag, " R3 first product at edge 3"},
                    $signed(acc_out), prod(bx, by));
            if (k == n + 1) begin
                chk(done == 1'b0, {tag, " R3 done not early"}, done, 0);
                chk(busy == 1'b1, {tag, " R7 busy through N+1"}, busy, 1);
            end
            if (k == n + 2) begin
                chk(done == 1'b1, {tag, " R3 done at N+2"}, done, 1);
                chk(busy == 1'b0, {tag, " R7 busy low at done"}, busy, 0);
                chk($signed(acc_out) == exp, {tag, " R2 R9 dot product"}, $signed(acc_out), exp);
            end
            if (k == n + 3) begin
                chk(done == 1'b0, {tag, " R4 done one cycle"}, done, 0);
                chk($signed(acc_out) == exp, {tag, " R4 acc held"}, $signed(acc_out), exp);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin ma[i] = '0; mb[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(acc_out == '0, "R1 acc after reset", acc_out, 0);

        // R11 load both banks through the write ports
        for (int i = 0; i < 256; i++) begin
            logic [15:0] da, db;
            da = 16'(i * 1237 - 20000);
            db = 16'(30000 - i * 991);
            if (i == 0) begin da = 16'h8000; db = 16'h7FFF; end
            if (i == 255) begin da = 16'h7FFF; db = 16'h8000; end
            write_both(i, da, db);
        end

        // Vector table walk (R2, R3, R9)
        for (int v = 0; v < NVEC; v++)
            run(int'(VECS[v].bx), int'(VECS[v].by), int'(VECS[v].n), -1, $sformatf("vec%0d", v));

        // R6 zero count
        @(negedge clk);
        start = 1'b1; count = 9'd0;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R6 zero count done", done, 1);
        chk(acc_out == '0, "R6 zero count acc", $signed(acc_out), 0);
        chk(busy == 1'b0, "R6 zero count not busy", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R6 zero count done one cycle", done, 0);

        // R8 second start mid-run ignored
        run(10, 20, 8, 2, "R8 start while busy");

        // R11 rewrite one word, then a run sees it
        write_both(60, 16'd3, 16'hFFFB);
        run(60, 60, 1, -1, "R11 rewritten word");

        // R10 full scale 256 products of -32768 * -32768
        for (int i = 0; i < 256; i++) write_both(i, 16'h8000, 16'h8000);
        run(0, 0, 256, -1, "R10 full scale");
        chk($signed(acc_out) == (40'sd1 <<< 38), "R10 sum equals 2^38",
            $signed(acc_out), 64'd1 << 38);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule